// File: doc/BRIEF.md
# Two-Step Subranging Converter Sequencer

This block is the digital controller for a half-flash analog-to-digital converter. The analog part has two comparator banks, a track/hold stage, a small reconstruction DAC and a subtractor. A conversion runs in two steps. First the coarse bank's thermometer word is registered and turned into the upper half of the result. That code is driven to the reconstruction DAC. After a programmable number of settle clocks, the fine bank's thermometer word is registered. The fine bank quantises the residue, which is the held input minus the DAC output.

The fine bank is one bit wider than the coarse half and is read as a signed correction around the coarse code. A wrong coarse decision is therefore repaired in the digital domain. The corrected sum is clamped to the output range and registered together with a one-cycle valid strobe.

The block also drives the track/hold control. A new coarse sample may be taken on the same edge that captures the fine word of the previous sample, so coarse and fine steps of successive samples overlap.

Top module: `subrange_adc_seq`

## Requirements
- R1: While reset is asserted and after it is released, `hold_o`, `busy_o` and `valid_o` are 0, and `data_o` and `dac_code_o` are 0.
- R2: A start is accepted on a rising edge where `start_i`=1 and `busy_o`=0. On that edge the coarse thermometer word is registered. From the next cycle `dac_code_o` equals the number of ones in the registered word.
- R3: The settle value S is sampled on the accepting edge. `busy_o` is 1 in the S cycles that follow that edge and 0 afterwards. The fine word is registered on edge S+1 counted from the accepting edge.
- R4: `hold_o` is 1 from the cycle after the accepting edge up to and including the cycle that ends with the fine capture edge. It is 0 after that edge unless a new start was accepted on the same edge.
- R5: A start presented while `busy_o`=1 is ignored: the coarse code on `dac_code_o` does not change and no extra result is produced.
- R6: The result is `coarse*2^(RES_W/2) + fine - 2^(RES_W/2-1)`, clamped to the range 0 to 2^RES_W-1. It appears on `data_o` with `valid_o`=1 for exactly one cycle, in the cycle after edge S+2 counted from the accepting edge.
- R7: Each bank's code is the count of ones in its registered word. A word with bubbles therefore encodes to its ones count.
- R8: Samples are pipelined. The edge that captures the fine word of sample k may accept the start of sample k+1. Both results come out in order and are correct.
- R9: `dac_code_o` stays constant during every cycle in which `busy_o`=1 and on the following cycle.
- R10: `data_o` keeps the last result while `valid_o`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request to convert a new sample |
| settle_i | input | SET_W | DAC settle clocks, sampled when a start is accepted |
| coarse_th_i | input | 2^(RES_W/2)-1 | Coarse comparator bank thermometer word |
| fine_th_i | input | 2^(RES_W/2+1)-1 | Residue comparator bank thermometer word |
| busy_o | output | 1 | Settle window running; a start is not accepted |
| hold_o | output | 1 | Track/hold control, 1 = hold |
| dac_code_o | output | RES_W/2 | Coarse code to the reconstruction DAC |
| data_o | output | RES_W | Corrected conversion result |
| valid_o | output | 1 | One-cycle strobe marking a new result |

## Verification
Timing is counted from the edge that accepts a start, called edge 0. The DAC code is due in the cycle after edge 0. `busy_o` stays high for S cycles. `hold_o` falls after edge S+1, and the result with its strobe is due after edge S+2. The bench drives inputs on falling edges and walks one falling edge at a time from edge 0, comparing every output against the value that the requirement fixes for that exact cycle index. For the overlapped case the bench follows the fixed schedule for settle value 1. It switches the fine word only after the capture edge of the earlier sample.

// File: rtl/subrange_adc_pkg.sv
package subrange_adc_pkg;

   // number of comparators that yield a code of the given width
   function automatic int therm_width(input int code_bits);
      return (1 << code_bits) - 1;
   endfunction

   // offset that centres the signed fine correction
   function automatic int fine_offset(input int coarse_bits);
      return 1 << (coarse_bits - 1);
   endfunction

endpackage

// File: rtl/subrange_therm_enc.sv
module subrange_therm_enc #(
   parameter int CODE_W = 4,
   parameter int TH_W   = 15
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cap_i,
   input  logic [TH_W-1:0]   therm_i,
   output logic [CODE_W-1:0] code_o
);

   localparam int PAIRS = TH_W / 2;
   localparam bit ODD   = (TH_W % 2) != 0;

   logic [TH_W-1:0] therm_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     therm_q <= '0;
      else if (cap_i) therm_q <= therm_i;
   end

   // first level: pairwise sums, a bubble only moves the count by its own weight
   logic [1:0] pair_sum [PAIRS];

   for (genvar g = 0; g < PAIRS; g++) begin : g_pair
      assign pair_sum[g] = {1'b0, therm_q[2*g]} + {1'b0, therm_q[2*g+1]};
   end

   logic [CODE_W-1:0] tail;
   if (ODD) begin : g_tail
      assign tail = CODE_W'(therm_q[TH_W-1]);
   end else begin : g_no_tail
      assign tail = '0;
   end

   always_comb begin
      code_o = tail;
      for (int i = 0; i < PAIRS; i++) begin
         code_o = code_o + CODE_W'(pair_sum[i]);
      end
   end

endmodule

// File: rtl/subrange_settle_timer.sv
module subrange_settle_timer #(
   parameter int SET_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load_i,
   input  logic [SET_W-1:0] load_val_i,
   output logic             active_o,
   output logic             busy_o,
   output logic             fire_o
);

   logic             active_q;
   logic [SET_W-1:0] cnt_q;

   assign active_o = active_q;
   assign busy_o   = active_q && (cnt_q != '0);
   assign fire_o   = active_q && (cnt_q == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active_q <= 1'b0;
         cnt_q    <= '0;
      end else if (load_i) begin
         active_q <= 1'b1;
         cnt_q    <= load_val_i;
      end else if (fire_o) begin
         active_q <= 1'b0;
      end else if (active_q) begin
         cnt_q    <= cnt_q - 1'b1;
      end
   end

endmodule

// File: rtl/subrange_merge.sv
module subrange_merge #(
   parameter int RES_W = 8,
   parameter int CRS_W = 4,
   parameter int FIN_W = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ready_i,
   input  logic [CRS_W-1:0] crs_i,
   input  logic [FIN_W-1:0] fin_i,
   output logic [RES_W-1:0] data_o,
   output logic             valid_o
);

   import subrange_adc_pkg::*;

   localparam int SUM_W = RES_W + 2;
   localparam int OFFS  = fine_offset(CRS_W);
   localparam int MAXV  = (1 << RES_W) - 1;

   logic signed [SUM_W-1:0] crs_s;
   logic signed [SUM_W-1:0] fin_s;
   logic signed [SUM_W-1:0] total;
   logic [RES_W-1:0]        clamped;

   always_comb begin
      crs_s = $signed(SUM_W'({crs_i, {CRS_W{1'b0}}}));
      fin_s = $signed(SUM_W'(fin_i));
      total = crs_s + fin_s - SUM_W'(OFFS);
      if (total < 0)
         clamped = '0;
      else if (total > SUM_W'(MAXV))
         clamped = '1;
      else
         clamped = total[RES_W-1:0];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         data_o  <= '0;
         valid_o <= 1'b0;
      end else begin
         valid_o <= ready_i;
         if (ready_i) data_o <= clamped;
      end
   end

endmodule

// File: rtl/subrange_adc_seq.sv
module subrange_adc_seq #(
   parameter int RES_W = 8,
   parameter int SET_W = 4,
   parameter int CRS_W = RES_W / 2,
   parameter int FIN_W = RES_W / 2 + 1,
   parameter int CTH_W = (1 << (RES_W / 2)) - 1,
   parameter int FTH_W = (1 << (RES_W / 2 + 1)) - 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_i,
   input  logic [SET_W-1:0] settle_i,
   input  logic [CTH_W-1:0] coarse_th_i,
   input  logic [FTH_W-1:0] fine_th_i,
   output logic             busy_o,
   output logic             hold_o,
   output logic [CRS_W-1:0] dac_code_o,
   output logic [RES_W-1:0] data_o,
   output logic             valid_o
);

   import subrange_adc_pkg::*;

   // elaboration-time parameter checks
   if (RES_W < 4 || (RES_W % 2) != 0) begin : g_bad_res
      $error("RES_W must be even and at least 4");
   end
   if (CRS_W != RES_W / 2 || FIN_W != CRS_W + 1) begin : g_bad_split
      $error("CRS_W/FIN_W must follow RES_W");
   end
   if (CTH_W != therm_width(CRS_W) || FTH_W != therm_width(FIN_W)) begin : g_bad_th
      $error("thermometer widths must match code widths");
   end
   if (SET_W < 1) begin : g_bad_set
      $error("SET_W must be at least 1");
   end

   logic             accept;
   logic             tmr_busy;
   logic             tmr_active;
   logic             tmr_fire;
   logic [CRS_W-1:0] crs_code;
   logic [FIN_W-1:0] fin_code;
   logic [CRS_W-1:0] crs_pipe_q;
   logic             fin_rdy_q;

   assign accept = start_i && !tmr_busy;

   subrange_therm_enc #(.CODE_W(CRS_W), .TH_W(CTH_W)) u_crs_enc (
      .clk     (clk),
      .rst_n   (rst_n),
      .cap_i   (accept),
      .therm_i (coarse_th_i),
      .code_o  (crs_code)
   );

   subrange_settle_timer #(.SET_W(SET_W)) u_timer (
      .clk        (clk),
      .rst_n      (rst_n),
      .load_i     (accept),
      .load_val_i (settle_i),
      .active_o   (tmr_active),
      .busy_o     (tmr_busy),
      .fire_o     (tmr_fire)
   );

   subrange_therm_enc #(.CODE_W(FIN_W), .TH_W(FTH_W)) u_fin_enc (
      .clk     (clk),
      .rst_n   (rst_n),
      .cap_i   (tmr_fire),
      .therm_i (fine_th_i),
      .code_o  (fin_code)
   );

   // coarse code of the sample whose fine word is being captured
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         crs_pipe_q <= '0;
         fin_rdy_q  <= 1'b0;
      end else begin
         fin_rdy_q <= tmr_fire;
         if (tmr_fire) crs_pipe_q <= crs_code;
      end
   end

   subrange_merge #(.RES_W(RES_W), .CRS_W(CRS_W), .FIN_W(FIN_W)) u_merge (
      .clk     (clk),
      .rst_n   (rst_n),
      .ready_i (fin_rdy_q),
      .crs_i   (crs_pipe_q),
      .fin_i   (fin_code),
      .data_o  (data_o),
      .valid_o (valid_o)
   );

   assign busy_o     = tmr_busy;
   assign hold_o     = tmr_active;
   assign dac_code_o = crs_code;

endmodule

// File: rtl/subrange_adc_seq_chk.sv
module subrange_adc_seq_chk #(
   parameter int RES_W = 8,
   parameter int CRS_W = 4
) (
   input logic             clk,
   input logic             rst_n,
   input logic             start_i,
   input logic             busy_o,
   input logic             hold_o,
   input logic [CRS_W-1:0] dac_code_o,
   input logic [RES_W-1:0] data_o,
   input logic             valid_o
);

   // R3
   busy_implies_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy_o |-> hold_o);

   // R9
   dac_code_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy_o |=> $stable(dac_code_o));

   // R4
   hold_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (start_i && !busy_o) |=> hold_o);

   // R6
   result_needs_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      valid_o |-> $past(hold_o, 2));

   // R10
   data_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !valid_o |-> $stable(data_o));

endmodule

bind subrange_adc_seq subrange_adc_seq_chk #(.RES_W(RES_W), .CRS_W(CRS_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .start_i    (start_i),
   .busy_o     (busy_o),
   .hold_o     (hold_o),
   .dac_code_o (dac_code_o),
   .data_o     (data_o),
   .valid_o    (valid_o)
);

// File: tb/subrange_adc_seq_bench.sv
module subrange_adc_seq_bench;

   localparam int RES_W = 8;
   localparam int SET_W = 4;
   localparam int CRS_W = RES_W / 2;
   localparam int FIN_W = CRS_W + 1;
   localparam int CTH_W = (1 << CRS_W) - 1;
   localparam int FTH_W = (1 << FIN_W) - 1;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             start_i = 1'b0;
   logic [SET_W-1:0] settle_i = '0;
   logic [CTH_W-1:0] coarse_th_i = '0;
   logic [FTH_W-1:0] fine_th_i = '0;
   logic             busy_o;
   logic             hold_o;
   logic [CRS_W-1:0] dac_code_o;
   logic [RES_W-1:0] data_o;
   logic             valid_o;

   int checks = 0;
   int failures = 0;
   int last_res = 0;

   always #2.5 clk = ~clk;

   subrange_adc_seq #(.RES_W(RES_W), .SET_W(SET_W)) u_subrange_adc_seq (
      .clk         (clk),
      .rst_n       (rst_n),
      .start_i     (start_i),
      .settle_i    (settle_i),
      .coarse_th_i (coarse_th_i),
      .fine_th_i   (fine_th_i),
      .busy_o      (busy_o),
      .hold_o      (hold_o),
      .dac_code_o  (dac_code_o),
      .data_o      (data_o),
      .valid_o     (valid_o)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
      end
   endtask

   function automatic int expect_res(input int c, input int f);
      int v;
      v = c * (1 << CRS_W) + f - (1 << (CRS_W - 1));
      if (v < 0) v = 0;
      if (v > (1 << RES_W) - 1) v = (1 << RES_W) - 1;
      return v;
   endfunction

   // one conversion, walked cycle by cycle from the accepting edge
   task automatic convert(input logic [CTH_W-1:0] cp, input logic [FTH_W-1:0] fp,
                          input int s, input bit inject);
      int ec;
      int ef;
      int er;
      ec = $countones(cp);
      ef = $countones(fp);
      er = expect_res(ec, ef);
      @(negedge clk);
      start_i = 1'b1; coarse_th_i = cp; fine_th_i = fp; settle_i = SET_W'(s);
      for (int j = 0; j <= s + 2; j++) begin
         @(negedge clk);
         if (j <= s) begin
            chk(hold_o == 1'b1, "R4 hold during settle", int'(hold_o), 1);
            chk(busy_o == (j < s), "R3 busy window", int'(busy_o), int'(j < s));
            chk(int'(dac_code_o) == ec, "R2 R7 R5 dac code", int'(dac_code_o), ec);
            chk(valid_o == 1'b0, "R6 no early valid", int'(valid_o), 0);
            chk(int'(data_o) == last_res, "R10 data kept", int'(data_o), last_res);
         end else if (j == s + 1) begin
            chk(hold_o == 1'b0, "R4 hold release", int'(hold_o), 0);
            chk(valid_o == 1'b0, "R6 valid timing", int'(valid_o), 0);
         end else begin
            chk(valid_o == 1'b1, "R6 valid pulse", int'(valid_o), 1);
            chk(int'(data_o) == er, "R6 R7 result", int'(data_o), er);
         end
         if (j == 0) begin
            start_i = inject;
            if (inject) coarse_th_i = ~cp;
         end else if (j == 1) begin
            start_i = 1'b0;
            coarse_th_i = cp;
         end
      end
      last_res = er;
   endtask

   task automatic finish_run();
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   endtask

   initial begin
      #(5.0 * 150000);
      failures++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      logic [CTH_W-1:0] cA;
      logic [CTH_W-1:0] cB;
      logic [FTH_W-1:0] fA;
      logic [FTH_W-1:0] fB;
      int eA;
      int eB;

      // R1: reset state
      repeat (3) @(negedge clk);
      chk(hold_o == 0 && busy_o == 0 && valid_o == 0, "R1 control outputs in reset",
          int'({hold_o, busy_o, valid_o}), 0);
      chk(data_o == 0 && dac_code_o == 0, "R1 data outputs in reset",
          int'(data_o) + int'(dac_code_o), 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(hold_o == 0 && busy_o == 0 && valid_o == 0, "R1 after release",
          int'({hold_o, busy_o, valid_o}), 0);

      // R6 R2 R3: exhaustive sweep of clean thermometer words, settle 0..3,
      // R5 starts injected during busy in part of the sweep
      for (int c = 0; c <= CTH_W; c++) begin
         for (int f = 0; f <= FTH_W; f++) begin
            convert(CTH_W'((1 << c) - 1), FTH_W'((1 << f) - 1), (c + f) % 4,
                    ((c + f) % 4 >= 2) && (f % 3 == 0));
         end
      end

      // R3: longest settle value
      convert(CTH_W'(15'h003f), FTH_W'(31'h0000_ffff), (1 << SET_W) - 1, 1'b1);

      // R7: bubbles in both banks
      convert(CTH_W'(15'b000_0000_0101_1011), FTH_W'(31'h0000_0f3d), 1, 1'b0);
      convert(CTH_W'(15'b110_1111_1111_1110), FTH_W'(31'h7ff7_7fff), 2, 1'b0);
      convert(CTH_W'(15'b000_0000_0000_0100), FTH_W'(31'h0000_0004), 0, 1'b0);

      // R8: overlapped samples with settle value 1
      cA = CTH_W'(15'h001f); fA = FTH_W'(31'h0000_07ff);
      cB = CTH_W'(15'h01ff); fB = FTH_W'(31'h0000_0003);
      eA = expect_res($countones(cA), $countones(fA));
      eB = expect_res($countones(cB), $countones(fB));
      @(negedge clk);
      start_i = 1'b1; coarse_th_i = cA; fine_th_i = fA; settle_i = SET_W'(1);
      @(negedge clk);                       // after edge 0
      start_i = 1'b0;
      chk(busy_o == 1'b1, "R8 busy for sample A", int'(busy_o), 1);
      @(negedge clk);                       // after edge 1
      chk(busy_o == 1'b0, "R8 accept window", int'(busy_o), 0);
      start_i = 1'b1; coarse_th_i = cB;
      @(negedge clk);                       // after edge 2: A fine taken, B coarse taken
      start_i = 1'b0; fine_th_i = fB;
      chk(hold_o == 1'b1, "R8 R4 hold kept", int'(hold_o), 1);
      chk(int'(dac_code_o) == $countones(cB), "R8 dac code of B",
          int'(dac_code_o), $countones(cB));
      chk(busy_o == 1'b1, "R8 busy for sample B", int'(busy_o), 1);
      chk(valid_o == 1'b0, "R8 no result yet", int'(valid_o), 0);
      @(negedge clk);                       // after edge 3
      chk(valid_o == 1'b1, "R8 valid for A", int'(valid_o), 1);
      chk(int'(data_o) == eA, "R8 result A", int'(data_o), eA);
      @(negedge clk);                       // after edge 4: B fine taken
      chk(valid_o == 1'b0, "R8 single pulse", int'(valid_o), 0);
      chk(hold_o == 1'b0, "R8 hold released", int'(hold_o), 0);
      @(negedge clk);                       // after edge 5
      chk(valid_o == 1'b1, "R8 valid for B", int'(valid_o), 1);
      chk(int'(data_o) == eB, "R8 result B", int'(data_o), eB);
      @(negedge clk);
      chk(valid_o == 1'b0 && int'(data_o) == eB, "R10 result held",
          int'(data_o), eB);

      finish_run();
   end

endmodule